// File: doc/BRIEF.md
# Keypad Matrix Scanner with Scan-Result Queue

This block scans a key matrix of up to 16 rows and 8 columns. It drives one row at a time and senses the columns. A key counts as pressed only if its column stays asserted for that row's whole scan window. The window is 16 clock cycles plus a programmable debounce count, so a longer debounce setting makes the scan slower.

At the end of each scan that found at least one key, the pressed keys are packed into up to eight one-byte entries and queued as one result in a four-deep queue. Software pops results through a small register interface. The register interface also holds:
- the control word (enable, interrupt enables, debounce count, queue threshold),
- a status word with write-one-to-clear flags and the pending-result count,
- one wake mask per row.

Two interrupt outputs are provided. One fires when the pending count reaches the programmed threshold. The other fires when a scan finds a pressed key that is not masked for wake-up.

Top module: `kp_scanner`

## Requirements
- R1: After reset, the status word, both entry words, every row drive line and both interrupt outputs are zero.
- R2: While enabled, rows are driven one at a time (active high) in ascending order. Each row is driven for 16 + debounce clock cycles, where debounce is control bits 13:4 (10 bits, so at most 0x3FF).
- R3: Between the last row of one scan and row 0 of the next, all rows are undriven for exactly 6 clock cycles.
- R4: A key is reported only if its column sense input was high on every cycle of its row's window; a contact that drops during the window is not reported.
- R5: Each entry byte is {valid (bit 7), row (bits 6:3), column (bits 2:0)}.
  - Entries follow ascending row-major order, and only the first eight pressed keys are kept.
  - Unused bytes read zero.
  - Address 2 returns entries 3..0, with entry 0 in bits 7:0; address 3 returns entries 7..4.
  - Both words read zero when the queue is empty.
- R6: A scan that finds at least one pressed key queues one result; a scan with no pressed key queues nothing. Status bits 7:4 give the pending-result count.
- R7: A read of address 3 pops the oldest result. A read of address 2 or of the status word leaves the count unchanged.
- R8: The queue holds 4 results. A result arriving while it is full is dropped, the count stays at 4, and the older results are kept.
- R9: Status bit 2 is set when a push brings the count to at least the threshold (control bits 17:14, nonzero). irq_fifo_o is status bit 2 AND control bit 3.
- R10: Address 16+r holds the wake mask of row r, where bit c masks column c.
  - Status bit 0 is set at the end of a scan that found a pressed key whose mask bit is 0.
  - irq_key_o is status bit 0 AND control bit 1.
- R11: Writing the status word clears each of bits 0 and 2 that is written as 1; bits written as 0 are unchanged.
- R12: Clearing control bit 0 stops scanning, with all rows undriven from the following cycle. Queued results are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| row_drive_o | output | NUM_ROWS | Row drive lines, active high |
| col_sense_i | input | NUM_COLS | Column sense lines, high when a key on the driven row is closed |
| irq_fifo_o | output | 1 | Queue-threshold interrupt |
| irq_key_o | output | 1 | Wake keypress interrupt |

## Verification
The assertions take the following for granted:
- column sense is a synchronous function of the row drive and the key state;
- each register access lasts a single cycle;
- the register interface never pops and the scanner never completes a scan in a way that depends on a simultaneous write to the same status bit.

The stimulus keeps within these limits in three ways. It drives the column lines from a key matrix ANDed with the driven row. It issues every access as a one-cycle strobe between clock edges. It changes the key pattern only while the scanner is disabled or between scans. A bouncing contact is modelled as a toggle, every five cycles, of one key inside that same matrix.

// File: rtl/kp_pkg.sv
package kp_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_ROWS,
        SQ_DONE
    } sq_state_e;

    // control word layout
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_KIE_BIT = 1;
    localparam int CTL_FIE_BIT = 3;
    localparam int CTL_DEB_LSB = 4;
    localparam int DEB_W       = 10;
    localparam int CTL_THR_LSB = 14;
    localparam int THR_W       = 4;

    // status word layout
    localparam int ST_KEY_BIT  = 0;
    localparam int ST_FIFO_BIT = 2;
    localparam int ST_CNT_LSB  = 4;
    localparam int ST_CNT_W    = 4;

    // entry byte layout
    localparam int ENT_W     = 8;
    localparam int ENT_ROW_W = 4;
    localparam int ENT_COL_W = 3;

    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] A_CTL       = 5'd0;
    localparam logic [ADDR_W-1:0] A_STAT      = 5'd1;
    localparam logic [ADDR_W-1:0] A_ENT_LO    = 5'd2;
    localparam logic [ADDR_W-1:0] A_ENT_HI    = 5'd3;
    localparam logic [ADDR_W-1:0] A_MASK_BASE = 5'd16;

endpackage

// File: rtl/kp_scan_seq.sv
module kp_scan_seq
    import kp_pkg::*;
#(
    parameter int NUM_ROWS    = 16,
    parameter int NUM_COLS    = 8,
    parameter int ROW_BASE    = 16,
    parameter int LEAD_CYCLES = 5,
    parameter int DEB_BITS    = 10
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         en_i,
    input  logic [DEB_BITS-1:0]          deb_i,
    input  logic [NUM_COLS-1:0]          col_i,
    output logic [NUM_ROWS-1:0]          row_o,
    output logic [NUM_ROWS*NUM_COLS-1:0] mat_o,
    output logic                         done_o
);
    localparam int CNT_W = $clog2(ROW_BASE + (1 << DEB_BITS) + LEAD_CYCLES) + 1;
    localparam int ROW_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

    typedef struct packed {
        sq_state_e                    st;
        logic [CNT_W-1:0]             cnt;
        logic [ROW_W-1:0]             row;
        logic [NUM_COLS-1:0]          acc;
        logic [NUM_ROWS*NUM_COLS-1:0] mat;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] win_last;
    logic             row_end;

    always_comb begin
        win_last = CNT_W'(ROW_BASE) + CNT_W'(deb_i) - CNT_W'(1);
        row_end  = (s_q.st == SQ_ROWS) && (s_q.cnt == win_last);
        s_d      = s_q;
        case (s_q.st)
            SQ_IDLE: begin
                s_d.st  = SQ_LEAD;
                s_d.cnt = '0;
            end
            SQ_LEAD: begin
                if (s_q.cnt == CNT_W'(LEAD_CYCLES - 1)) begin
                    s_d.st  = SQ_ROWS;
                    s_d.cnt = '0;
                    s_d.row = '0;
                    s_d.acc = '1;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            SQ_ROWS: begin
                // a key survives only if sensed on every cycle of the window
                s_d.acc = s_q.acc & col_i;
                if (row_end) begin
                    s_d.mat[s_q.row*NUM_COLS +: NUM_COLS] = s_q.acc & col_i;
                    s_d.acc = '1;
                    s_d.cnt = '0;
                    if (s_q.row == LAST_ROW) begin
                        s_d.st = SQ_DONE;
                    end else begin
                        s_d.row = s_q.row + ROW_W'(1);
                    end
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            default: begin
                s_d.st  = SQ_LEAD;
                s_d.cnt = '0;
            end
        endcase
        if (!en_i) begin
            s_d.st  = SQ_IDLE;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: SQ_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        row_o = '0;
        if (s_q.st == SQ_ROWS) begin
            row_o[s_q.row] = 1'b1;
        end
    end

    assign mat_o  = s_q.mat;
    assign done_o = (s_q.st == SQ_DONE);

    // R2: the drive moves to the next row at the end of a window
    p_row_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (row_end && s_q.row != LAST_ROW && en_i) |=> (row_o == ($past(row_o) << 1)));

    // R3: completion follows the last row window
    p_done_after_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (row_end && s_q.row == LAST_ROW && en_i) |=> (done_o && row_o == '0));

    // R12: dropping the enable releases all rows on the next cycle
    p_stop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (row_o == '0));

endmodule

// File: rtl/kp_entry_pack.sv
module kp_entry_pack
    import kp_pkg::*;
#(
    parameter int NUM_ROWS = 16,
    parameter int NUM_COLS = 8,
    parameter int MAX_KEYS = 8
) (
    input  logic [NUM_ROWS*NUM_COLS-1:0] mat_i,
    input  logic [NUM_ROWS*NUM_COLS-1:0] mask_i,
    output logic [MAX_KEYS*ENT_W-1:0]    entries_o,
    output logic                         any_o,
    output logic                         wake_o
);
    always_comb begin
        int n;
        n         = 0;
        entries_o = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            for (int c = 0; c < NUM_COLS; c++) begin
                if (mat_i[r*NUM_COLS + c]) begin
                    if (n < MAX_KEYS) begin
                        entries_o[n*ENT_W +: ENT_W] = {1'b1, ENT_ROW_W'(r), ENT_COL_W'(c)};
                    end
                    n = n + 1;
                end
            end
        end
    end

    assign any_o  = |mat_i;
    assign wake_o = |(mat_i & ~mask_i);

endmodule

// File: rtl/kp_result_fifo.sv
module kp_result_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  push_ok, pop_ok;

    always_comb begin
        push_ok = push_i && (f_q.cnt != CNT_FULL);
        pop_ok  = pop_i && (f_q.cnt != '0);
        f_d     = f_q;
        if (push_ok) begin
            f_d.mem[f_q.wr] = din_i;
            f_d.wr = (f_q.wr == PTR_LAST) ? '0 : f_q.wr + PTR_W'(1);
        end
        if (pop_ok) begin
            f_d.rd = (f_q.rd == PTR_LAST) ? '0 : f_q.rd + PTR_W'(1);
        end
        f_d.cnt = f_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign dout_o  = (f_q.cnt == '0) ? '0 : f_q.mem[f_q.rd];
    assign count_o = f_q.cnt;

    // R8: the count never exceeds the depth
    p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_o <= CNT_FULL);

    // R8: a push into a full queue is dropped
    p_full_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == CNT_FULL && push_i && !pop_i) |=> (count_o == CNT_FULL));

    // R7: a lone pop lowers the count by one
    p_pop_dec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && !push_i && count_o != '0) |=> (count_o == $past(count_o) - CNT_W'(1)));

    // R6: a lone push with room raises the count by one
    p_push_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && !pop_i && count_o != CNT_FULL) |=> (count_o == $past(count_o) + CNT_W'(1)));

endmodule

// File: rtl/kp_scanner.sv
module kp_scanner
    import kp_pkg::*;
#(
    parameter int NUM_ROWS    = 16,
    parameter int NUM_COLS    = 8,
    parameter int FIFO_DEPTH  = 4,
    parameter int ROW_BASE    = 16,
    parameter int LEAD_CYCLES = 5
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bus_en_i,
    input  logic                bus_we_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    output logic [NUM_ROWS-1:0] row_drive_o,
    input  logic [NUM_COLS-1:0] col_sense_i,
    output logic                irq_fifo_o,
    output logic                irq_key_o
);
    localparam int MAX_KEYS = 8;
    localparam int RES_W    = MAX_KEYS * ENT_W;
    localparam int KEYS_N   = NUM_ROWS * NUM_COLS;
    localparam int FCNT_W   = $clog2(FIFO_DEPTH + 1);
    localparam logic [FCNT_W-1:0] FCNT_FULL = FCNT_W'(FIFO_DEPTH);

    typedef struct packed {
        logic                               en;
        logic                               kie;
        logic                               fie;
        logic [DEB_W-1:0]                   deb;
        logic [THR_W-1:0]                   thr;
        logic                               st_key;
        logic                               st_fifo;
        logic [NUM_ROWS-1:0][NUM_COLS-1:0]  mask;
    } regs_t;

    regs_t r_d, r_q;

    logic [KEYS_N-1:0]    mat;
    logic                 scan_done;
    logic [RES_W-1:0]     packed_res;
    logic                 any_key;
    logic                 wake_key;
    logic [RES_W-1:0]     head;
    logic [FCNT_W-1:0]    fifo_cnt;
    logic                 wr_acc, rd_hi, push_ok, pop_ok, set_fifo, set_key;
    logic [ST_CNT_W-1:0]  cnt_after;
    logic [ADDR_W-1:0]    mask_off;

    kp_scan_seq #(
        .NUM_ROWS   (NUM_ROWS),
        .NUM_COLS   (NUM_COLS),
        .ROW_BASE   (ROW_BASE),
        .LEAD_CYCLES(LEAD_CYCLES),
        .DEB_BITS   (DEB_W)
    ) u_seq (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_i  (r_q.en),
        .deb_i (r_q.deb),
        .col_i (col_sense_i),
        .row_o (row_drive_o),
        .mat_o (mat),
        .done_o(scan_done)
    );

    kp_entry_pack #(
        .NUM_ROWS(NUM_ROWS),
        .NUM_COLS(NUM_COLS),
        .MAX_KEYS(MAX_KEYS)
    ) u_pack (
        .mat_i    (mat),
        .mask_i   (r_q.mask),
        .entries_o(packed_res),
        .any_o    (any_key),
        .wake_o   (wake_key)
    );

    kp_result_fifo #(
        .DEPTH(FIFO_DEPTH),
        .WIDTH(RES_W)
    ) u_fifo (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (scan_done && any_key),
        .pop_i  (rd_hi),
        .din_i  (packed_res),
        .dout_o (head),
        .count_o(fifo_cnt)
    );

    always_comb begin
        wr_acc    = bus_en_i && bus_we_i;
        rd_hi     = bus_en_i && !bus_we_i && (bus_addr_i == A_ENT_HI);
        pop_ok    = rd_hi && (fifo_cnt != '0);
        push_ok   = scan_done && any_key && (fifo_cnt != FCNT_FULL);
        cnt_after = ST_CNT_W'(fifo_cnt) + ST_CNT_W'(push_ok) - ST_CNT_W'(pop_ok);
        set_fifo  = push_ok && (r_q.thr != '0) && (cnt_after >= ST_CNT_W'(r_q.thr));
        set_key   = scan_done && wake_key;
        mask_off  = bus_addr_i - A_MASK_BASE;

        r_d = r_q;
        if (wr_acc && bus_addr_i == A_CTL) begin
            r_d.en  = bus_wdata_i[CTL_EN_BIT];
            r_d.kie = bus_wdata_i[CTL_KIE_BIT];
            r_d.fie = bus_wdata_i[CTL_FIE_BIT];
            r_d.deb = bus_wdata_i[CTL_DEB_LSB +: DEB_W];
            r_d.thr = bus_wdata_i[CTL_THR_LSB +: THR_W];
        end
        if (wr_acc && bus_addr_i == A_STAT) begin
            if (bus_wdata_i[ST_KEY_BIT])  r_d.st_key  = 1'b0;
            if (bus_wdata_i[ST_FIFO_BIT]) r_d.st_fifo = 1'b0;
        end
        if (set_key)  r_d.st_key  = 1'b1;
        if (set_fifo) r_d.st_fifo = 1'b1;
        for (int r = 0; r < NUM_ROWS; r++) begin
            if (wr_acc && bus_addr_i >= A_MASK_BASE && mask_off == ADDR_W'(r)) begin
                r_d.mask[r] = bus_wdata_i[NUM_COLS-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == A_CTL) begin
            bus_rdata_o[CTL_EN_BIT]               = r_q.en;
            bus_rdata_o[CTL_KIE_BIT]              = r_q.kie;
            bus_rdata_o[CTL_FIE_BIT]              = r_q.fie;
            bus_rdata_o[CTL_DEB_LSB +: DEB_W]     = r_q.deb;
            bus_rdata_o[CTL_THR_LSB +: THR_W]     = r_q.thr;
        end else if (bus_addr_i == A_STAT) begin
            bus_rdata_o[ST_KEY_BIT]               = r_q.st_key;
            bus_rdata_o[ST_FIFO_BIT]              = r_q.st_fifo;
            bus_rdata_o[ST_CNT_LSB +: ST_CNT_W]   = ST_CNT_W'(fifo_cnt);
        end else if (bus_addr_i == A_ENT_LO) begin
            bus_rdata_o = head[31:0];
        end else if (bus_addr_i == A_ENT_HI) begin
            bus_rdata_o = head[63:32];
        end else if (bus_addr_i >= A_MASK_BASE) begin
            for (int r = 0; r < NUM_ROWS; r++) begin
                if (mask_off == ADDR_W'(r)) begin
                    bus_rdata_o[NUM_COLS-1:0] = r_q.mask[r];
                end
            end
        end
    end

    assign irq_fifo_o = r_q.st_fifo && r_q.fie;
    assign irq_key_o  = r_q.st_key && r_q.kie;

    // R11: a one written to the queue flag clears it unless a new push sets it
    p_w1c_fifo_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_acc && bus_addr_i == A_STAT && bus_wdata_i[ST_FIFO_BIT] && !push_ok)
            |=> !r_q.st_fifo);

    // R10: an unmasked key at scan end raises the keypress flag
    p_key_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scan_done && wake_key) |=> r_q.st_key);

    // R5: the entry words read zero while the queue is empty
    p_empty_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_en_i && !bus_we_i && bus_addr_i == A_ENT_LO && fifo_cnt == '0)
            |-> (bus_rdata_o == '0));

endmodule

// File: tb/kp_scanner_tb.sv
module kp_scanner_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NR-1:0] row_drive;
    logic [NC-1:0] col_sense;
    logic          irq_fifo, irq_key;

    logic [NR-1:0][NC-1:0] keys = '0;
    logic          bounce_on = 1'b0;
    logic          bounce_ph = 1'b0;
    int            bounce_cnt = 0;
    int            n_tests = 0;
    int            n_fail = 0;
    int            cyc = 0;

    kp_scanner u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bus_en_i   (bus_en),
        .bus_we_i   (bus_we),
        .bus_addr_i (bus_addr),
        .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata),
        .row_drive_o(row_drive),
        .col_sense_i(col_sense),
        .irq_fifo_o (irq_fifo),
        .irq_key_o  (irq_key)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // key matrix model; key (4,2) opens every other 5-cycle phase when bouncing
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            col_sense[c] = 1'b0;
            for (int r = 0; r < NR; r++) begin
                if (row_drive[r] && keys[r][c] &&
                    !(bounce_on && bounce_ph && r == 4 && c == 2))
                    col_sense[c] = 1'b1;
            end
        end
    end

    always @(posedge clk) begin
        bounce_cnt <= (bounce_cnt == 4) ? 0 : bounce_cnt + 1;
        if (bounce_cnt == 4) bounce_ph <= ~bounce_ph;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    function automatic logic [31:0] mk_ctl(bit en, bit kie, bit fie, int deb, int thr);
        return 32'(en) | (32'(kie) << 1) | (32'(fie) << 3) | (32'(deb) << 4) | (32'(thr) << 14);
    endfunction

    function automatic logic [63:0] exp_pack(logic [NR-1:0][NC-1:0] k);
        logic [63:0] v = '0;
        int n = 0;
        for (int r = 0; r < NR; r++) begin
            for (int c = 0; c < NC; c++) begin
                if (k[r][c]) begin
                    if (n < 8) v[n*8 +: 8] = {1'b1, 4'(r), 3'(c)};
                    n++;
                end
            end
        end
        return v;
    endfunction

    task automatic wait_scan_end();
        @(negedge clk);
        while (!row_drive[NR-1]) @(negedge clk);
        while (row_drive[NR-1]) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic get_count(output int n);
        logic [31:0] s;
        rd(5'd1, s);
        n = int'(s[7:4]);
    endtask

    task automatic drain();
        logic [31:0] d;
        int n;
        get_count(n);
        for (int i = 0; i < n; i++) rd(5'd3, d);
    endtask

    task automatic one_scan(input logic [31:0] ctl);
        wr(5'd0, ctl);
        wait_scan_end();
        wr(5'd0, 32'd0);
    endtask

    initial begin
        logic [31:0] d, lo, hi;
        logic [63:0] e;
        int n;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 rows", 64'(row_drive), 64'd0);
        chk("R1 irqs", 64'({irq_fifo, irq_key}), 64'd0);
        rd(5'd1, d); chk("R1 status", 64'(d), 64'd0);
        rd(5'd2, d); chk("R1 entry lo", 64'(d), 64'd0);

        // R2 row window and order, R3 gap between scans
        wr(5'd0, mk_ctl(1, 0, 0, 3, 0));
        @(negedge clk);
        while (row_drive != 16'h0001) @(negedge clk);
        n = 0;
        while (row_drive == 16'h0001) begin n++; @(negedge clk); end
        chk("R2 row window 16+3", 64'(n), 64'd19);
        chk("R2 next row", 64'(row_drive), 64'h0002);
        while (!row_drive[NR-1]) @(negedge clk);
        while (row_drive[NR-1]) @(negedge clk);
        n = 0;
        while (row_drive == '0) begin n++; @(negedge clk); end
        chk("R3 gap cycles", 64'(n), 64'd6);
        chk("R3 restarts row 0", 64'(row_drive), 64'h0001);
        wr(5'd0, 32'd0);
        drain();

        // R5/R6/R7 single key
        keys = '0; keys[3][5] = 1'b1;
        one_scan(mk_ctl(1, 0, 0, 0, 0));
        get_count(n); chk("R6 count one", 64'(n), 64'd1);
        rd(5'd2, d); chk("R5 single entry", 64'(d), 64'h9D);
        rd(5'd2, d);
        get_count(n); chk("R7 lo read no pop", 64'(n), 64'd1);
        rd(5'd3, d); chk("R5 upper word empty", 64'(d), 64'd0);
        get_count(n); chk("R7 hi read pops", 64'(n), 64'd0);

        // R5 more than eight keys
        keys = '0; keys[0] = 8'hFF; keys[1][2:0] = 3'b111;
        one_scan(mk_ctl(1, 0, 0, 0, 0));
        rd(5'd2, lo); rd(5'd3, hi);
        chk("R5 first eight keys", {hi, lo}, 64'h8786858483828180);

        // R6 no key queues nothing
        keys = '0;
        one_scan(mk_ctl(1, 0, 0, 0, 0));
        get_count(n); chk("R6 no key no push", 64'(n), 64'd0);

        // R4 bouncing contact rejected, stable key kept
        keys = '0; keys[4][2] = 1'b1; keys[6][7] = 1'b1; bounce_on = 1'b1;
        one_scan(mk_ctl(1, 0, 0, 0, 0));
        bounce_on = 1'b0;
        rd(5'd2, lo); rd(5'd3, hi);
        chk("R4 bounce rejected", {hi, lo}, 64'hB7);

        // R8 overflow keeps oldest four
        keys = '0; keys[2][1] = 1'b1;
        wr(5'd0, mk_ctl(1, 0, 0, 0, 0));
        repeat (4) wait_scan_end();
        keys = '0; keys[5][6] = 1'b1;
        repeat (2) wait_scan_end();
        wr(5'd0, 32'd0);
        get_count(n); chk("R8 count saturates", 64'(n), 64'd4);
        for (int i = 0; i < 4; i++) begin
            rd(5'd2, d); chk("R8 oldest kept", 64'(d), 64'h91);
            rd(5'd3, d);
        end
        get_count(n); chk("R8 drained", 64'(n), 64'd0);

        // R9 threshold interrupt, R11 write-one-to-clear
        keys = '0; keys[7][0] = 1'b1;
        wr(5'd1, 32'h5);
        one_scan(mk_ctl(1, 0, 1, 0, 2));
        wr(5'd0, mk_ctl(0, 0, 1, 0, 2));
        rd(5'd1, d); chk("R9 below threshold", 64'(d[2]), 64'd0);
        one_scan(mk_ctl(1, 0, 1, 0, 2));
        wr(5'd0, mk_ctl(0, 0, 1, 0, 2));
        rd(5'd1, d); chk("R9 flag at threshold", 64'(d[2]), 64'd1);
        @(negedge clk); chk("R9 irq fifo", 64'(irq_fifo), 64'd1);
        chk("R10 irq key gated off", 64'(irq_key), 64'd0);
        wr(5'd1, 32'h1);
        rd(5'd1, d); chk("R11 zero bit kept", 64'(d[2]), 64'd1);
        chk("R11 key flag cleared", 64'(d[0]), 64'd0);
        wr(5'd1, 32'h4);
        rd(5'd1, d); chk("R11 fifo flag cleared", 64'(d[2]), 64'd0);
        @(negedge clk); chk("R9 irq fifo low", 64'(irq_fifo), 64'd0);
        drain();

        // R10 wake mask
        keys = '0; keys[3][5] = 1'b1;
        wr(5'd19, 32'hFF);
        rd(5'd19, d); chk("R10 mask readback", 64'(d), 64'hFF);
        one_scan(mk_ctl(1, 1, 0, 0, 0));
        wr(5'd0, mk_ctl(0, 1, 0, 0, 0));
        rd(5'd1, d); chk("R10 masked row", 64'(d[0]), 64'd0);
        @(negedge clk); chk("R10 irq key masked", 64'(irq_key), 64'd0);
        wr(5'd19, 32'hDF);
        one_scan(mk_ctl(1, 1, 0, 0, 0));
        wr(5'd0, mk_ctl(0, 1, 0, 0, 0));
        rd(5'd1, d); chk("R10 unmasked key", 64'(d[0]), 64'd1);
        @(negedge clk); chk("R10 irq key", 64'(irq_key), 64'd1);
        wr(5'd1, 32'h5);
        wr(5'd19, 32'h0);
        drain();

        // R12 disable mid-scan keeps queue
        keys = '0; keys[1][1] = 1'b1;
        one_scan(mk_ctl(1, 0, 0, 0, 0));
        wr(5'd0, mk_ctl(1, 0, 0, 0, 0));
        @(negedge clk);
        while (row_drive == '0) @(negedge clk);
        wr(5'd0, 32'd0);
        @(negedge clk); @(negedge clk);
        chk("R12 rows released", 64'(row_drive), 64'd0);
        repeat (300) @(negedge clk);
        chk("R12 stays idle", 64'(row_drive), 64'd0);
        get_count(n); chk("R12 queue kept", 64'(n), 64'd1);
        drain();

        // R5/R6 random key patterns
        for (int it = 0; it < 12; it++) begin
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < NC; c++)
                    keys[r][c] = (($urandom % 16) == 0);
            e = exp_pack(keys);
            one_scan(mk_ctl(1, 0, 0, 0, 0));
            get_count(n);
            chk("R6 random count", 64'(n), (keys != '0) ? 64'd1 : 64'd0);
            rd(5'd2, lo); rd(5'd3, hi);
            chk("R5 random entries", {hi, lo}, e);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule